// File: doc/BRIEF.md
# Unaligned Watch Region Splitter

This block breaks a memory region, given as a start address and a byte length, into a run of naturally aligned chunks. Each chunk is a power-of-two size no larger than a configured maximum (4 or 8 bytes), and its address is a multiple of its size, so one watch slot can cover it. In insert or remove mode each chunk is presented on a chunk port, one per cycle while the downstream side is ready. In count mode no chunk is presented; the block only counts how many slots the region would take and reports whether that fits in the slot budget.

A request is taken with a one-cycle `start` while the block is idle. The block walks the region from low to high addresses. After each accepted chunk it moves the address forward by the chunk size and takes the size off the remaining length. A per-chunk failure returned by the downstream side is ORed into a sticky flag, and the walk goes on, so later chunks that could share an existing slot are still issued. When the length is used up, `done` pulses for one cycle. The count, the failure flag and the fit flag stay valid until the next request.

Top module: `watch_region_splitter`

## Requirements
- R1: After reset the block is idle: `busy`, `chunk_valid` and `done` are 0, and `chunk_count` and `any_fail` are 0.
- R2: When the length is 1, 2, 4, or 8 (8 only with an 8-byte maximum) and the address is a multiple of the length, the region goes out as exactly one chunk of that length at that address.
- R3: Every chunk size is the largest power of two that is no more than the remaining length, no more than the maximum width, and divides the current address. Every chunk address is a multiple of its size.
- R4: Chunks are contiguous. The first starts at the request address, each next one starts at the previous address plus the previous size, and the sizes add up to the request length.
- R5: While `chunk_valid` is 1 and `chunk_ready` is 0, the chunk address, size and direction hold steady. A chunk is consumed only in a cycle where `chunk_ready` is 1.
- R6: In insert or remove mode, a `chunk_fail` on any consumed chunk sets `any_fail`. All remaining chunks are still issued. `any_fail` clears when the next request starts.
- R7: In count mode (`op` 2'b10 or 2'b11) `chunk_valid` stays 0. One chunk is counted per cycle, so `done` comes N+1 cycles after `start` is taken for a region of N chunks.
- R8: `chunk_count` gives the number of chunks in the last request. `region_fits` is 1 exactly when that count is 4 or less.
- R9: A request with length 0 gives `done` in the cycle after `start` is taken, with count 0, `any_fail` 0 and no chunk.
- R10: `done` is a single-cycle pulse after the last chunk. `chunk_valid` is 0 while `done` is 1, and the block is idle in the next cycle.
- R11: `chunk_remove` is 0 for `op` 2'b00 (insert) and 1 for `op` 2'b01 (remove).
- R12: Chunks of 8 bytes appear only when the maximum width is 8. With a maximum of 4, an aligned 8-byte region takes two 4-byte chunks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe; taken only while idle |
| op | input | 2 | 00 insert, 01 remove, 1x count |
| addr | input | ADDR_W | Region start address |
| len | input | LEN_W | Region length in bytes |
| busy | output | 1 | A request is in progress |
| chunk_valid | output | 1 | A chunk is presented |
| chunk_ready | input | 1 | Downstream takes the chunk this cycle |
| chunk_remove | output | 1 | 1 = remove chunk, 0 = insert chunk |
| chunk_addr | output | ADDR_W | Chunk start address |
| chunk_size | output | 4 | Chunk size in bytes (1, 2, 4, 8) |
| chunk_fail | input | 1 | Downstream failed the chunk being taken |
| done | output | 1 | One-cycle completion pulse |
| any_fail | output | 1 | Sticky OR of chunk failures for the request |
| chunk_count | output | LEN_W+1 | Chunks in the last request |
| region_fits | output | 1 | Chunk count is within the slot budget |

## Verification
The assertions assume that `chunk_fail` is only meaningful while a chunk is being taken, and that the downstream side may stall without limit. They also assume `start` has no effect while `busy` is 1. The bench raises `start` only when both instances are idle and holds it for exactly one cycle. It drives `chunk_ready` in a fixed stall pattern on the falling edge, which keeps the hold property exercised. It drives `chunk_fail` as a combinational match on the presented chunk address, so the flag never goes out of step with the chunk it refers to.

// File: rtl/wrs_pkg.sv
package wrs_pkg;

   typedef enum logic [1:0] {
      OP_INSERT = 2'b00,
      OP_REMOVE = 2'b01,
      OP_COUNT  = 2'b10,
      OP_COUNT2 = 2'b11
   } wrs_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_RUN  = 2'b01,
      ST_DONE = 2'b10
   } wrs_state_e;

   localparam int SIZE_W = 4;

endpackage

// File: rtl/wrs_chunk_sizer.sv
module wrs_chunk_sizer
   import wrs_pkg::*;
#(
   parameter int MAX_CHUNK = 8,
   parameter int LEN_W     = 8
) (
   input  logic [2:0]        addr_lo,
   input  logic [LEN_W-1:0]  rem_len,
   input  logic              first_chunk,
   output logic [SIZE_W-1:0] size
);

   localparam int ALIGN_W = (MAX_CHUNK == 8) ? 3 : 2;

   logic [SIZE_W-1:0] cap_sz;
   logic [SIZE_W-1:0] align_sz;
   logic [SIZE_W-1:0] table_sz;
   logic              direct_ok;

   // Length cap: largest power of two not above min(remaining, maximum)
   always_comb begin
      if (rem_len >= LEN_W'(MAX_CHUNK))      cap_sz = SIZE_W'(MAX_CHUNK);
      else if (rem_len >= LEN_W'(4))         cap_sz = 4'd4;
      else if (rem_len >= LEN_W'(2))         cap_sz = 4'd2;
      else                                   cap_sz = 4'd1;
   end

   // Alignment cap: address modulo the maximum width
   generate
      if (MAX_CHUNK == 8) begin : g_align8
         always_comb begin
            if (addr_lo[ALIGN_W-1:0] == '0) align_sz = 4'd8;
            else if (addr_lo[0])            align_sz = 4'd1;
            else if (addr_lo[1])            align_sz = 4'd2;
            else                            align_sz = 4'd4;
         end
      end else begin : g_align4
         always_comb begin
            if (addr_lo[ALIGN_W-1:0] == '0) align_sz = 4'd4;
            else if (addr_lo[0])            align_sz = 4'd1;
            else                            align_sz = 4'd2;
         end
      end
   endgenerate

   assign table_sz = (cap_sz < align_sz) ? cap_sz : align_sz;

   // Already-aligned region of a legal size goes out whole
   always_comb begin
      direct_ok = 1'b0;
      if (first_chunk) begin
         case (rem_len)
            LEN_W'(1): direct_ok = 1'b1;
            LEN_W'(2): direct_ok = (addr_lo[0] == 1'b0);
            LEN_W'(4): direct_ok = (addr_lo[1:0] == 2'b00);
            LEN_W'(8): direct_ok = (MAX_CHUNK == 8) && (addr_lo == 3'b000);
            default:   direct_ok = 1'b0;
         endcase
      end
   end

   assign size = direct_ok ? SIZE_W'(rem_len) : table_sz;

endmodule

// File: rtl/wrs_tally.sv
module wrs_tally #(
   parameter int CNT_W      = 9,
   parameter int SLOT_LIMIT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   input  logic             step_fail,
   output logic [CNT_W-1:0] count,
   output logic             fail,
   output logic             fits
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
         fail  <= 1'b0;
      end else if (clear) begin
         count <= '0;
         fail  <= 1'b0;
      end else if (step) begin
         count <= count + CNT_W'(1);
         fail  <= fail | step_fail;
      end
   end

   assign fits = (count <= CNT_W'(SLOT_LIMIT));

endmodule

// File: rtl/watch_region_splitter.sv
module watch_region_splitter
   import wrs_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 8,
   parameter int MAX_CHUNK  = 8,
   parameter int SLOT_LIMIT = 4,
   localparam int CNT_W     = LEN_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        op,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LEN_W-1:0]  len,
   output logic              busy,
   output logic              chunk_valid,
   input  logic              chunk_ready,
   output logic              chunk_remove,
   output logic [ADDR_W-1:0] chunk_addr,
   output logic [3:0]        chunk_size,
   input  logic              chunk_fail,
   output logic              done,
   output logic              any_fail,
   output logic [CNT_W-1:0]  chunk_count,
   output logic              region_fits
);

   generate
      if (MAX_CHUNK != 4 && MAX_CHUNK != 8) begin : g_bad_max
         $error("MAX_CHUNK must be 4 or 8");
      end
      if (LEN_W < 4) begin : g_bad_len
         $error("LEN_W must be at least 4");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("ADDR_W must be at least 4");
      end
      if (SLOT_LIMIT < 1) begin : g_bad_slots
         $error("SLOT_LIMIT must be positive");
      end
   endgenerate

   wrs_state_e        state_q;
   logic [ADDR_W-1:0] cur_addr_q;
   logic [LEN_W-1:0]  rem_q;
   logic              count_mode_q;
   logic              remove_q;
   logic              first_q;
   logic [SIZE_W-1:0] size_w;
   logic              accept;
   logic              step;
   logic              last;

   wrs_chunk_sizer #(
      .MAX_CHUNK (MAX_CHUNK),
      .LEN_W     (LEN_W)
   ) sizer_i (
      .addr_lo     (cur_addr_q[2:0]),
      .rem_len     (rem_q),
      .first_chunk (first_q),
      .size        (size_w)
   );

   assign accept = (state_q == ST_IDLE) && start;
   assign step   = (state_q == ST_RUN) && (count_mode_q || chunk_ready);
   assign last   = (rem_q <= LEN_W'(size_w));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         cur_addr_q   <= '0;
         rem_q        <= '0;
         count_mode_q <= 1'b0;
         remove_q     <= 1'b0;
         first_q      <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  cur_addr_q   <= addr;
                  rem_q        <= len;
                  count_mode_q <= op[1];
                  remove_q     <= (op == OP_REMOVE);
                  first_q      <= 1'b1;
                  state_q      <= (len == '0) ? ST_DONE : ST_RUN;
               end
            end
            ST_RUN: begin
               if (step) begin
                  cur_addr_q <= cur_addr_q + ADDR_W'(size_w);
                  rem_q      <= last ? '0 : rem_q - LEN_W'(size_w);
                  first_q    <= 1'b0;
                  if (last) state_q <= ST_DONE;
               end
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   wrs_tally #(
      .CNT_W      (CNT_W),
      .SLOT_LIMIT (SLOT_LIMIT)
   ) tally_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (accept),
      .step      (step),
      .step_fail (!count_mode_q && chunk_fail),
      .count     (chunk_count),
      .fail      (any_fail),
      .fits      (region_fits)
   );

   assign busy         = (state_q != ST_IDLE);
   assign chunk_valid  = (state_q == ST_RUN) && !count_mode_q;
   assign chunk_remove = remove_q;
   assign chunk_addr   = cur_addr_q;
   assign chunk_size   = size_w;
   assign done         = (state_q == ST_DONE);

endmodule

// File: rtl/watch_region_splitter_chk.sv
module watch_region_splitter_chk #(
   parameter int ADDR_W    = 32,
   parameter int MAX_CHUNK = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              chunk_valid,
   input logic              chunk_ready,
   input logic              chunk_remove,
   input logic [ADDR_W-1:0] chunk_addr,
   input logic [3:0]        chunk_size,
   input logic              done
);

   // R5: a stalled chunk holds its contents
   a_r5_hold_chunk: assert property (@(posedge clk) disable iff (!rst_n)
      (chunk_valid && !chunk_ready) |=>
         (chunk_valid && $stable(chunk_addr) && $stable(chunk_size) && $stable(chunk_remove)));

   // R3: chunk address is a multiple of its size
   a_r3_natural_align: assert property (@(posedge clk) disable iff (!rst_n)
      chunk_valid |-> ((chunk_addr[3:0] & (chunk_size - 4'd1)) == 4'd0));

   // R12: size is a power of two within the maximum width
   a_r12_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
      chunk_valid |-> ($onehot(chunk_size) && (int'(chunk_size) <= MAX_CHUNK)));

   // R4: the next chunk starts where the taken one ended
   a_r4_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
      (chunk_valid && chunk_ready) |=>
         (chunk_valid |-> (chunk_addr == $past(chunk_addr) + ADDR_W'($past(chunk_size)))));

   // R10: completion is a one-cycle pulse with no chunk beside it
   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !chunk_valid);

   // R1: nothing is presented while idle
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!chunk_valid && !done));

endmodule

bind watch_region_splitter watch_region_splitter_chk #(
   .ADDR_W    (ADDR_W),
   .MAX_CHUNK (MAX_CHUNK)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy         (busy),
   .chunk_valid  (chunk_valid),
   .chunk_ready  (chunk_ready),
   .chunk_remove (chunk_remove),
   .chunk_addr   (chunk_addr),
   .chunk_size   (chunk_size),
   .done         (done)
);

// File: tb/watch_region_splitter_tb_top.sv
module watch_region_splitter_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int LW = 8;
   localparam int CW = LW + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [1:0]    op = 2'b00;
   logic [AW-1:0] addr = '0;
   logic [LW-1:0] len = '0;
   logic          chunk_ready = 1'b1;
   logic          chunk_fail;

   logic          busy8, cv8, crm8, done8, fail8, fits8;
   logic [AW-1:0] ca8;
   logic [3:0]    cs8;
   logic [CW-1:0] cnt8;
   logic          busy4, cv4, crm4, done4, fail4, fits4;
   logic [AW-1:0] ca4;
   logic [3:0]    cs4;
   logic [CW-1:0] cnt4;

   int checks = 0;
   int failures = 0;

   bit            fail_en = 1'b0;
   logic [AW-1:0] fail_addr = '0;
   bit            stall_on = 1'b0;
   bit            mon_count_mode = 1'b0;
   bit            exp_remove = 1'b0;
   int            exp_addr [64];
   int            exp_size [64];
   int            exp_n = 0;
   int            mon_idx = 0;
   int            cyc = 0;
   bit            done4_seen = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign chunk_fail = fail_en && cv8 && (ca8 == fail_addr);

   watch_region_splitter #(.ADDR_W(AW), .LEN_W(LW), .MAX_CHUNK(8), .SLOT_LIMIT(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr), .len(len),
      .busy(busy8), .chunk_valid(cv8), .chunk_ready(chunk_ready), .chunk_remove(crm8),
      .chunk_addr(ca8), .chunk_size(cs8), .chunk_fail(chunk_fail), .done(done8),
      .any_fail(fail8), .chunk_count(cnt8), .region_fits(fits8));

   watch_region_splitter #(.ADDR_W(AW), .LEN_W(LW), .MAX_CHUNK(4), .SLOT_LIMIT(4)) dut_n_i (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr), .len(len),
      .busy(busy4), .chunk_valid(cv4), .chunk_ready(chunk_ready), .chunk_remove(crm4),
      .chunk_addr(ca4), .chunk_size(cs4), .chunk_fail(1'b0), .done(done4),
      .any_fail(fail4), .chunk_count(cnt4), .region_fits(fits4));

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int model_size(longint a, int rem, int mx);
      int s = mx;
      while (s > rem || (a % s) != 0) s = s / 2;
      return s;
   endfunction

   function automatic int model_count(longint a, int l, int mx);
      int n = 0;
      while (l > 0) begin
         int s = model_size(a, l, mx);
         a += s;
         l -= s;
         n++;
      end
      return n;
   endfunction

   // Monitor chunk handshakes, then update the ready pattern
   always @(negedge clk) begin
      if (rst_n && cv8 && mon_count_mode)
         chk(1'b0, "R7 chunk_valid in count mode", 1, 0);
      if (rst_n && cv4 && mon_count_mode)
         chk(1'b0, "R7 chunk_valid in count mode (max4)", 1, 0);
      if (rst_n && cv8 && chunk_ready && !mon_count_mode) begin
         if (mon_idx < exp_n) begin
            chk(ca8 == AW'(exp_addr[mon_idx]), "R4 chunk address", ca8, exp_addr[mon_idx]);
            chk(int'(cs8) == exp_size[mon_idx], "R3 chunk size", cs8, exp_size[mon_idx]);
            chk(crm8 == exp_remove, "R11 chunk direction", crm8, exp_remove);
         end else begin
            chk(1'b0, "R4 extra chunk", mon_idx, exp_n);
         end
         mon_idx++;
      end
      if (done4) done4_seen = 1'b1;
      cyc++;
      chunk_ready = !stall_on || ((cyc % 3) != 0);
   end

   // Issue one request, wait for completion; returns cycles to done
   task automatic run_req(input logic [1:0] o, input int a, input int l,
                          input bit stall, input bit fen, input int fa,
                          output int lat);
      longint cur = a;
      int rem = l;
      exp_n = 0;
      while (rem > 0) begin
         int s = model_size(cur, rem, 8);
         exp_addr[exp_n] = int'(cur);
         exp_size[exp_n] = s;
         exp_n++;
         cur += s;
         rem -= s;
      end
      mon_idx = 0;
      exp_remove = (o == 2'b01);
      mon_count_mode = o[1];
      stall_on = stall;
      fail_en = fen;
      fail_addr = AW'(fa);
      done4_seen = 1'b0;
      @(negedge clk);
      op = o; addr = AW'(a); len = LW'(l); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done8 && lat < 400) begin
         @(negedge clk);
         lat++;
      end
      if (!done8) chk(1'b0, "R10 done never seen", lat, 0);
   endtask

   task automatic wait_idle();
      int n = 0;
      while ((busy8 || busy4) && n < 400) begin
         @(negedge clk);
         n++;
      end
      stall_on = 1'b0;
      fail_en = 1'b0;
      mon_count_mode = 1'b0;
   endtask

   task automatic t_reset();
      chk(!busy8 && !cv8 && !done8, "R1 idle after reset", {busy8, cv8, done8}, 0);
      chk(cnt8 == 0 && !fail8, "R1 count and fail clear", cnt8, 0);
   endtask

   task automatic t_aligned_single();
      int lat;
      run_req(2'b00, 32'h100, 4, 1'b0, 1'b0, 0, lat);
      chk(cnt8 == 1, "R2 aligned 4-byte region one chunk", cnt8, 1);
      chk(mon_idx == 1, "R2 one chunk presented", mon_idx, 1);
      chk(!fail8, "R6 no failure", fail8, 0);
      @(negedge clk);
      chk(!done8 && !busy8, "R10 done single pulse then idle", {done8, busy8}, 0);
      wait_idle();
      run_req(2'b00, 32'h208, 8, 1'b0, 1'b0, 0, lat);
      chk(cnt8 == 1 && mon_idx == 1, "R2 aligned 8-byte region one chunk", cnt8, 1);
      wait_idle();
      chk(cnt4 == 2, "R12 max4 splits aligned 8 bytes in two", cnt4, 2);
   endtask

   task automatic t_unaligned_stall();
      int lat;
      run_req(2'b00, 32'h1003, 10, 1'b1, 1'b0, 0, lat);
      chk(mon_idx == exp_n, "R4 all chunks presented under stalls", mon_idx, exp_n);
      chk(cnt8 == CW'(exp_n), "R8 count after insert", cnt8, exp_n);
      wait_idle();
   endtask

   task automatic t_remove_fail();
      int lat;
      run_req(2'b01, 32'h2001, 14, 1'b0, 1'b1, 32'h2002, lat);
      chk(fail8, "R6 failure recorded", fail8, 1);
      chk(mon_idx == exp_n, "R6 chunks continue after failure", mon_idx, exp_n);
      wait_idle();
      run_req(2'b00, 32'h40, 2, 1'b0, 1'b0, 0, lat);
      chk(!fail8, "R6 failure cleared on new request", fail8, 0);
      chk(cnt8 == 1, "R2 aligned 2-byte region", cnt8, 1);
      wait_idle();
   endtask

   task automatic t_count_mode();
      int lat;
      int n8;
      int n4;
      n8 = model_count(1, 13, 8);
      n4 = model_count(1, 13, 4);
      run_req(2'b10, 1, 13, 1'b1, 1'b0, 0, lat);
      chk(cnt8 == CW'(n8), "R7 count mode chunk count", cnt8, n8);
      chk(lat == n8 + 1, "R7 one chunk per cycle", lat, n8 + 1);
      chk(fits8 == (n8 <= 4), "R8 fits flag over budget", fits8, n8 <= 4);
      wait_idle();
      chk(done4_seen && cnt4 == CW'(n4), "R7 count mode max4", cnt4, n4);
      run_req(2'b11, 1, 9, 1'b0, 1'b0, 0, lat);
      chk(cnt8 == 4 && fits8, "R8 exactly four chunks fits", cnt8, 4);
      wait_idle();
      run_req(2'b10, 3, 24, 1'b0, 1'b0, 0, lat);
      n8 = model_count(3, 24, 8);
      n4 = model_count(3, 24, 4);
      chk(cnt8 == CW'(n8), "R3 long region count max8", cnt8, n8);
      wait_idle();
      chk(cnt4 == CW'(n4), "R12 long region count max4", cnt4, n4);
   endtask

   task automatic t_zero_len();
      int lat;
      run_req(2'b00, 32'h77, 0, 1'b0, 1'b0, 0, lat);
      chk(lat == 1, "R9 zero length completes next cycle", lat, 1);
      chk(cnt8 == 0 && !fail8 && fits8, "R9 zero length count", cnt8, 0);
      chk(mon_idx == 0, "R9 zero length no chunk", mon_idx, 0);
      wait_idle();
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      chk(1'b0, "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_aligned_single();
      t_unaligned_stall();
      t_remove_fail();
      t_count_mode();
      t_zero_len();
      repeat (3) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule